// File: doc/BRIEF.md
# Redundant-Code Pipeline Digital Correction

This block sits behind the analog stages of a pipelined converter and builds one binary result per sample from the small codes those stages emit. Every stage hands over a 2-bit code worth 0, 1 or 2. The first stage carries the heaviest weight, and each later stage weighs half as much as the one before it. A stage reports its code for a given sample one clock after the stage ahead of it. Because a new sample enters the first stage each cycle, the lanes of the input bus belong to different samples at any moment.

The block first registers and sanitises all lanes. It then delays each lane just far enough that the codes of one sample meet in the same cycle. The codes are weighted and summed so that the low bit of each stage overlaps the high bit of the next, and any carry ripples toward the MSB. The sum is registered together with an output strobe. The overlap is what makes the result tolerant of a shifted comparator threshold: a stage that decides one step too high or too low hands a residue to the next stage, and that stage compensates in the sum.

Top module: `pipe_code_corrector`

## Requirements
- R1: With NSTAGE stages, stage k (k = 1 is the most significant) is read from `codes_i[2*(NSTAGE-k)+1 : 2*(NSTAGE-k)]`. The code 2'b00 means 0, 2'b01 means 1 and 2'b10 means 2.
- R2: For each valid sample, `word_o` is NSTAGE+1 bits wide and equals the sum over k of code_k * 2^(NSTAGE-k).
- R3: A sample is framed by `in_valid_i` high in the cycle that stage 1's code is presented, and stage k's code is presented k-1 cycles later. Its result and `out_valid_o` become visible right after the NSTAGE-th rising edge that follows the edge which sampled `in_valid_i`.
- R4: `out_valid_o` repeats the `in_valid_i` pattern cycle for cycle, delayed by that latency, for back-to-back samples and for samples with gaps between them.
- R5: While `out_valid_o` is low, `word_o` keeps its last value. Codes presented without a valid frame have no effect on it.
- R6: An input code of 2'b11 is summed as if it were 2'b10.
- R7: `err_o` rises right after any edge that samples 2'b11 on any lane outside reset. It then stays high until reset and never rises without such a code.
- R8: A synchronous active-high `rst` drives `word_o` to 0 and lowers `out_valid_o` and `err_o`. It also discards samples in flight, so none of them ever raises `out_valid_o`.
- R9: Two code sets with the same weighted sum give the same word. An example is a stage reading 2 with the next reading 0, against 1 followed by 2. The largest result, with every stage at 2'b10, is 2^(NSTAGE+1)-2 and fits without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | High when stage 1's code starts a new sample |
| codes_i | input | 2*NSTAGE | All stage codes, stage 1 in the top two bits |
| word_o | output | NSTAGE+1 | Corrected binary result |
| out_valid_o | output | 1 | High for one cycle per corrected result |
| err_o | output | 1 | Sticky flag set by a 2'b11 code |

## Verification
The bench drives lanes skewed exactly as a real pipeline would. A design that delays one lane by the wrong amount therefore mixes codes from neighbouring samples, and back-to-back vectors with distinct sums expose it as a wrong word. Two code sets that differ only by a threshold-shift pattern must yield the same word, and an all-2 sample must reach the top value without wrapping; a design that joined bits instead of adding overlapped weights would fail both. Valid gaps filled with nonzero codes catch a word register that loads while unframed. A 2'b11 sample checks both the clamp and the sticky flag. A reset pulsed while a sample is in flight catches alignment registers that were not cleared, which would let a phantom result escape.

// File: rtl/pcc_pkg.sv
package pcc_pkg;

    typedef logic [1:0] code_t;

    localparam code_t CODE_ZERO = 2'b00;
    localparam code_t CODE_ONE  = 2'b01;
    localparam code_t CODE_TWO  = 2'b10;
    localparam code_t CODE_BAD  = 2'b11;

    // Sanitised lane: the usable code plus a flag that the raw code was illegal.
    typedef struct packed {
        logic  bad;
        code_t code;
    } lane_t;

    function automatic lane_t sanitise(code_t raw);
        lane_t l;
        l.bad  = (raw == CODE_BAD);
        l.code = l.bad ? CODE_TWO : raw;
        return l;
    endfunction

endpackage

// File: rtl/pcc_capture.sv
module pcc_capture #(
    parameter int NSTAGE = 6,
    localparam int BUSW  = 2 * NSTAGE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_i,
    input  logic [BUSW-1:0] codes_i,
    output logic [BUSW-1:0] lanes_o,
    output logic            valid_o,
    output logic            err_o
);
    import pcc_pkg::*;

    logic [NSTAGE-1:0] bad_lane;
    logic [BUSW-1:0]   clean;

    for (genvar i = 0; i < NSTAGE; i++) begin : g_lane
        lane_t l;
        assign l                   = sanitise(codes_i[2*i +: 2]);
        assign clean[2*i +: 2]     = l.code;
        assign bad_lane[i]         = l.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_o <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            lanes_o <= clean;
            valid_o <= valid_i;
            err_o   <= err_o | (|bad_lane);
        end
    end

endmodule

// File: rtl/pcc_skew_line.sv
module pcc_skew_line #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    if (DEPTH == 0) begin : g_through
        assign q = d;
    end else begin : g_regs
        logic [WIDTH-1:0] tap [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
            end else begin
                tap[0] <= d;
                for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
            end
        end

        assign q = tap[DEPTH-1];
    end

endmodule

// File: rtl/pcc_weighted_sum.sv
module pcc_weighted_sum #(
    parameter int NSTAGE = 6,
    localparam int BUSW  = 2 * NSTAGE,
    localparam int OUTW  = NSTAGE + 1
) (
    input  logic [BUSW-1:0] lanes_i,
    output logic [OUTW-1:0] sum_o
);
    import pcc_pkg::*;

    // Stage s (0-based, 0 = most significant) sits at lane bits 2*(NSTAGE-1-s)
    // and carries weight 2^(NSTAGE-1-s); adjacent weights overlap by one bit.
    always_comb begin
        logic [OUTW-1:0] acc;
        acc = '0;
        for (int s = 0; s < NSTAGE; s++) begin
            code_t c;
            c   = lanes_i[2*(NSTAGE-1-s) +: 2];
            acc = acc + ({{(OUTW-2){1'b0}}, c} << (NSTAGE-1-s));
        end
        sum_o = acc;
    end

endmodule

// File: rtl/pipe_code_corrector.sv
module pipe_code_corrector #(
    parameter int NSTAGE = 6,
    localparam int BUSW  = 2 * NSTAGE,
    localparam int OUTW  = NSTAGE + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid_i,
    input  logic [BUSW-1:0] codes_i,
    output logic [OUTW-1:0] word_o,
    output logic            out_valid_o,
    output logic            err_o
);
    logic [BUSW-1:0] cap_lanes;
    logic            cap_valid;
    logic [BUSW-1:0] aligned;
    logic            aligned_valid;
    logic [OUTW-1:0] sum;

    pcc_capture #(.NSTAGE(NSTAGE)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .valid_i (in_valid_i),
        .codes_i (codes_i),
        .lanes_o (cap_lanes),
        .valid_o (cap_valid),
        .err_o   (err_o)
    );

    // Triangular bank: stage s waits NSTAGE-1-s cycles for the last stage to catch up.
    for (genvar s = 0; s < NSTAGE; s++) begin : g_skew
        pcc_skew_line #(.WIDTH(2), .DEPTH(NSTAGE - 1 - s)) u_line (
            .clk (clk),
            .rst (rst),
            .d   (cap_lanes[2*(NSTAGE-1-s) +: 2]),
            .q   (aligned[2*(NSTAGE-1-s) +: 2])
        );
    end

    // The strobe travels with stage 1, the longest path.
    pcc_skew_line #(.WIDTH(1), .DEPTH(NSTAGE - 1)) u_vline (
        .clk (clk),
        .rst (rst),
        .d   (cap_valid),
        .q   (aligned_valid)
    );

    pcc_weighted_sum #(.NSTAGE(NSTAGE)) u_sum (
        .lanes_i (aligned),
        .sum_o   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_o      <= '0;
            out_valid_o <= 1'b0;
        end else begin
            out_valid_o <= aligned_valid;
            if (aligned_valid) word_o <= sum;
        end
    end

endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
    parameter int NSTAGE = 6,
    localparam int BUSW  = 2 * NSTAGE,
    localparam int OUTW  = NSTAGE + 1
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid_i,
    input logic [BUSW-1:0] codes_i,
    input logic [OUTW-1:0] word_o,
    input logic            out_valid_o,
    input logic            err_o
);
    localparam logic [OUTW-1:0] TOP_WORD = {{(OUTW-1){1'b1}}, 1'b0};

    logic saw_bad;
    always_comb begin
        saw_bad = 1'b0;
        for (int i = 0; i < NSTAGE; i++)
            if (codes_i[2*i +: 2] == 2'b11) saw_bad = 1'b1;
    end

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid_o && !err_o && word_o == '0));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    assert_bad_code_flags_R7: assert property (@(posedge clk) disable iff (rst)
        saw_bad |=> err_o);

    assert_word_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!out_valid_o && !$past(rst)) |-> $stable(word_o));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid_o |-> (word_o <= TOP_WORD));

endmodule

bind pipe_code_corrector pcc_checker #(.NSTAGE(NSTAGE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .codes_i     (codes_i),
    .word_o      (word_o),
    .out_valid_o (out_valid_o),
    .err_o       (err_o)
);

// File: tb/pipe_code_corrector_test.sv
module pipe_code_corrector_test;
    localparam int N = 6;
    localparam int W = N + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [2*N-1:0] codes = '0;
    logic [W-1:0]   word;
    logic           out_valid;
    logic           err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    pipe_code_corrector #(.NSTAGE(N)) uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .codes_i     (codes),
        .word_o      (word),
        .out_valid_o (out_valid),
        .err_o       (err)
    );

    // Stage 1 in the top bits; weights 32,16,8,4,2,1 (R1, R2).
    localparam logic [2*N-1:0] VEC_CODE [8] = '{
        12'h000, 12'hAAA, 12'h555, 12'h991, 12'hA11, 12'h400, 12'h002, 12'h249};
    localparam logic [W-1:0] VEC_EXP [8] = '{
        7'd0, 7'd126, 7'd63, 7'd101, 7'd101, 7'd32, 7'd2, 7'd45};

    logic [2*N-1:0] s_code [32];
    logic           s_vld  [32];
    logic [W-1:0]   s_exp  [32];
    int             s_len;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Lane of stage i+1 carries the sample that entered i cycles earlier (R3).
    task automatic drive_cycle(int c);
        in_valid = (c >= 0 && c < s_len) ? s_vld[c] : 1'b0;
        for (int i = 0; i < N; i++) begin
            int s;
            s = c - i;
            codes[2*(N-1-i) +: 2] = (s >= 0 && s < s_len) ? s_code[s][2*(N-1-i) +: 2] : 2'b00;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; codes = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_stream(logic [W-1:0] held_start);
        logic [W-1:0] held;
        held = held_start;
        for (int c = 0; c < s_len + N + 1; c++) begin
            @(negedge clk);
            drive_cycle(c);
            @(posedge clk);
            #1;
            if (c - N >= 0 && c - N < s_len) begin
                check("R3 R4 valid strobe", out_valid, s_vld[c-N]);
                if (s_vld[c-N]) begin
                    check("R2 R3 corrected word", word, s_exp[c-N]);
                    held = s_exp[c-N];
                end else begin
                    check("R5 word held in gap", word, held);
                end
            end else begin
                check("R4 no strobe outside frames", out_valid, 1'b0);
            end
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        #1;
        check("R8 reset word", word, 0);
        check("R8 reset valid", out_valid, 0);
        check("R8 reset err", err, 0);

        // Back-to-back table walk (R1, R2, R3, R9).
        s_len = 8;
        for (int i = 0; i < 8; i++) begin
            s_code[i] = VEC_CODE[i]; s_vld[i] = 1'b1; s_exp[i] = VEC_EXP[i];
        end
        run_stream('0);
        check("R7 no false error", err, 0);

        // Gaps carrying junk codes (R4, R5).
        s_len = 6;
        s_code[0] = 12'h991; s_vld[0] = 1; s_exp[0] = 7'd101;
        s_code[1] = 12'h555; s_vld[1] = 0; s_exp[1] = 7'd0;
        s_code[2] = 12'h2AA; s_vld[2] = 0; s_exp[2] = 7'd0;
        s_code[3] = 12'h002; s_vld[3] = 1; s_exp[3] = 7'd2;
        s_code[4] = 12'hAAA; s_vld[4] = 0; s_exp[4] = 7'd0;
        s_code[5] = 12'h400; s_vld[5] = 1; s_exp[5] = 7'd32;
        run_stream(7'd45);
        check("R7 no false error after gaps", err, 0);

        // Illegal codes clamp to 2 and set the sticky flag (R6, R7).
        s_len = 3;
        s_code[0] = 12'hFFF; s_vld[0] = 1; s_exp[0] = 7'd126;
        s_code[1] = 12'h249; s_vld[1] = 1; s_exp[1] = 7'd45;
        s_code[2] = 12'hF00; s_vld[2] = 1; s_exp[2] = 7'd96;
        run_stream(7'd32);
        check("R7 error flag set and sticky", err, 1);

        // Reset while a sample is in flight (R8).
        @(negedge clk);
        s_len = 1; s_code[0] = 12'hAAA; s_vld[0] = 1;
        drive_cycle(0);
        @(negedge clk); drive_cycle(1);
        @(negedge clk); drive_cycle(2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0; codes = '0;
        #1;
        check("R8 err cleared", err, 0);
        check("R8 word cleared", word, 0);
        for (int c = 0; c < N + 3; c++) begin
            @(posedge clk);
            #1;
            check("R8 flushed sample never emerges", out_valid, 0);
        end
        check("R8 word still zero", word, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule